// File: doc/BRIEF.md
# Panel Pixel Stream Output Stage

This block sits at the display end of a video pipeline. Pixel words arrive from a frame store in bursts. They are parked in a local FIFO, and a fresh burst is requested whenever the fill level drops to half of the FIFO depth. On the panel side the block produces its own scan timing: a one-cycle pixel strobe, horizontal and vertical sync, and a data-valid flag. Each FIFO word is shown on exactly one data-valid pixel, in the same registered cycle as the strobe and sync levels that frame it.

A horizontal counter and a vertical counter share one parameterised layout of active span, front porch, sync width and back porch. With the default values (800 by 525 positions, strobe at one quarter of a 100 MHz clock) the scan repeats about 60 times per second. After reset the scan starts on the first line of vertical front porch, which gives the memory side one full blanking interval to fill the FIFO. If the FIFO is dry on a visible pixel, the block shows black and latches a sticky underflow flag.

Top module: `lcd_stream_out`

## Requirements
- R1: While reset is held and in the cycle after it, refill_req, de, pix_ce and underflow are 0, pix_data is 0, and hsync and vsync sit at their inactive level.
- R2: pix_ce is a one-cycle pulse that repeats every PIX_DIV clocks. de, hsync, vsync and pix_data hold their values in every cycle where pix_ce is low.
- R3: A line spans H_ACT+H_FP+H_SYNC+H_BP strobes. Pixel positions count from 0. Sync is asserted from position H_ACT+H_FP for H_SYNC positions, and de can be high only at positions below H_ACT.
- R4: A frame spans V_ACT+V_FP+V_SYNC+V_BP lines. vsync is asserted from line V_ACT+V_FP for V_SYNC lines, and de is high only on lines below V_ACT. The first strobe after reset shows line V_ACT, pixel 0.
- R5: With HS_ACTIVE_HIGH and VS_ACTIVE_HIGH at their default of 0, an asserted sync drives the pin to 0 and an idle sync drives it to 1.
- R6: Stored words appear on pix_data in the order they were accepted, one word per strobe with de high. pix_data is 0 whenever de is low.
- R7: When no burst is open and the fill level is at or below DEPTH/2, refill_req rises on the next clock.
- R8: Once raised, refill_req stays high until exactly BURST (100) words have been accepted. It falls on the clock that accepts the last word and stays low for at least one cycle.
- R9: A word presented on wr_valid while refill_req is low is discarded and never reaches pix_data.
- R10: A strobe with de high that finds the FIFO empty shows pix_data = 0 and sets underflow. Only reset clears underflow.
- R11: An accepted word never finds the FIFO full, because DEPTH/2 + BURST does not exceed DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Burst word present from memory side |
| wr_data | input | DATA_W | Burst word |
| refill_req | output | 1 | Burst request, held for one whole burst |
| pix_ce | output | 1 | Pixel strobe; panel samples outputs in this cycle |
| hsync | output | 1 | Horizontal sync, polarity set by parameter |
| vsync | output | 1 | Vertical sync, polarity set by parameter |
| de | output | 1 | Visible pixel flag |
| pix_data | output | DATA_W | Pixel word, 0 outside visible region or on underflow |
| underflow | output | 1 | Sticky: a visible pixel found the FIFO empty |

## Verification
A corrupted scan counter shows up as a sync or de edge at the wrong strobe. The bench recomputes every strobe's position from the strobe count since reset, so the first displaced edge is caught within one line. A read pointer or level that slips shows as a pixel word out of sequence on the next visible pixel, or as refill_req rising too early or too late against the fill level the bench tracks from words written and words shown. A broken burst counter shows as refill_req falling at any count other than 100, which is checked when the request drops.

// File: rtl/lcdo_pkg.sv
package lcdo_pkg;
  // true when pos lies in [first, first+len)
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned first,
                                   input int unsigned len);
    return (pos >= first) && (pos < first + len);
  endfunction
endpackage

// File: rtl/lcdo_axis.sv
module lcdo_axis #(
  parameter int ACT   = 640,
  parameter int FP    = 16,
  parameter int SYNC  = 96,
  parameter int BP    = 48,
  parameter int START = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic wrap,
  output logic active,
  output logic sync
);
  localparam int TOT = ACT + FP + SYNC + BP;
  localparam int W   = $clog2(TOT);

  logic [W-1:0] pos;

  assign wrap   = step && (pos == W'(TOT - 1));
  assign active = (pos < W'(ACT));
  assign sync   = lcdo_pkg::in_span(32'(pos), ACT + FP, SYNC);

  always_ff @(posedge clk) begin
    if (rst)       pos <= W'(START);
    else if (step) pos <= wrap ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/lcdo_fifo.sv
module lcdo_fifo #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_data   <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      level <= level + LW'(wr_en) - LW'(rd_en);
    end
  end
endmodule

// File: rtl/lcdo_refill.sv
module lcdo_refill #(
  parameter int BURST = 100,
  parameter int DEPTH = 256,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(BURST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic          wr_en,
  output logic          req,
  output logic [BW-1:0] taken
);
  localparam int HALF = DEPTH / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      taken <= '0;
    end else if (req) begin
      if (wr_en) begin
        if (taken == BW'(BURST - 1)) begin
          req   <= 1'b0;
          taken <= '0;
        end else begin
          taken <= taken + 1'b1;
        end
      end
    end else if (level <= LW'(HALF)) begin
      req <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_stream_out.sv
module lcd_stream_out #(
  parameter int DATA_W  = 24,
  parameter int DEPTH   = 256,
  parameter int BURST   = 100,
  parameter int PIX_DIV = 4,
  parameter int H_ACT   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_ACT   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter bit HS_ACTIVE_HIGH = 1'b0,
  parameter bit VS_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              refill_req,
  output logic              pix_ce,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [DATA_W-1:0] pix_data,
  output logic              underflow
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(BURST);
  localparam int DW = $clog2(PIX_DIV);

  // pixel strobe divider
  logic [DW-1:0] div_cnt;
  logic          ce;
  assign ce = (div_cnt == DW'(PIX_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)     div_cnt <= '0;
    else if (ce) div_cnt <= '0;
    else         div_cnt <= div_cnt + 1'b1;
  end

  // scan position
  logic h_wrap, h_act, h_sync, v_wrap, v_act, v_sync;

  lcdo_axis #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .START(0)) u_h (
    .clk(clk), .rst(rst), .step(ce),
    .wrap(h_wrap), .active(h_act), .sync(h_sync));

  lcdo_axis #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .START(V_ACT)) u_v (
    .clk(clk), .rst(rst), .step(h_wrap),
    .wrap(v_wrap), .active(v_act), .sync(v_sync));

  logic vis;
  assign vis = h_act && v_act;

  // buffer and refill control
  logic [DATA_W-1:0] rd_data;
  logic [LW-1:0]     fifo_level;
  logic [BW-1:0]     burst_cnt;
  logic              fifo_empty, fifo_full, wr_en, rd_en;

  assign wr_en = wr_valid && refill_req && !fifo_full;
  assign rd_en = ce && vis && !fifo_empty;

  lcdo_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .level(fifo_level),
    .empty(fifo_empty), .full(fifo_full));

  lcdo_refill #(.BURST(BURST), .DEPTH(DEPTH)) u_refill (
    .clk(clk), .rst(rst), .level(fifo_level), .wr_en(wr_en),
    .req(refill_req), .taken(burst_cnt));

  // registered panel outputs, updated only on strobe cycles
  logic have_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_ce    <= 1'b0;
      de        <= 1'b0;
      have_word <= 1'b0;
      hsync     <= ~HS_ACTIVE_HIGH;
      vsync     <= ~VS_ACTIVE_HIGH;
      underflow <= 1'b0;
    end else begin
      pix_ce <= ce;
      if (ce) begin
        de        <= vis;
        have_word <= vis && !fifo_empty;
        hsync     <= HS_ACTIVE_HIGH ? h_sync : ~h_sync;
        vsync     <= VS_ACTIVE_HIGH ? v_sync : ~v_sync;
        if (vis && fifo_empty) underflow <= 1'b1;
      end
    end
  end

  assign pix_data = have_word ? rd_data : '0;
endmodule

// File: rtl/lcdo_checker.sv
module lcdo_checker #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 256,
  parameter int BURST  = 100,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(BURST)
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_ce,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic [DATA_W-1:0] pix_data,
  input logic              underflow,
  input logic              refill_req,
  input logic              wr_valid,
  input logic [LW-1:0]     level,
  input logic [BW-1:0]     burst_cnt
);
  localparam int HALF = DEPTH / 2;

  // R2: strobe is a single-cycle pulse
  p_ce_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    pix_ce |=> !pix_ce);

  // R2: panel outputs move only with the strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pix_ce |-> ($stable(de) && $stable(hsync) && $stable(vsync) && $stable(pix_data)));

  // R6: black outside the visible region
  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix_data == '0));

  // R7: request follows a half-empty level
  p_req_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (!refill_req && level <= LW'(HALF)) |=> refill_req);

  // R8: request held through the burst
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (refill_req && !(wr_valid && burst_cnt == BW'(BURST - 1))) |=> refill_req);

  // R8: request released on the last word
  p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (refill_req && wr_valid && burst_cnt == BW'(BURST - 1)) |=> !refill_req);

  // R10: underflow stays set
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  // R11: an accepted word always has room
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (refill_req && wr_valid) |-> (level < LW'(DEPTH)));
endmodule

bind lcd_stream_out lcdo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST(BURST)) u_chk (
  .clk(clk), .rst(rst), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
  .de(de), .pix_data(pix_data), .underflow(underflow),
  .refill_req(refill_req), .wr_valid(wr_valid),
  .level(fifo_level), .burst_cnt(burst_cnt));

// File: tb/lcd_stream_out_bench.sv
module lcd_stream_out_bench;
  localparam int DW = 24, DEPTH = 256, BURST = 100, DIV = 2;
  localparam int HA = 6, HF = 2, HS = 2, HB = 2, HT = HA + HF + HS + HB;
  localparam int VA = 4, VF = 1, VS = 1, VB = 20, VT = VA + VF + VS + VB;
  localparam int HALF = DEPTH / 2;

  logic clk = 1'b0, rst = 1'b1, wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic refill_req, pix_ce, hsync, vsync, de, underflow;
  logic [DW-1:0] pix_data;

  always #5 clk = ~clk;

  lcd_stream_out #(.DATA_W(DW), .DEPTH(DEPTH), .BURST(BURST), .PIX_DIV(DIV),
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) u_lcd_stream_out (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .refill_req(refill_req), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_data(pix_data), .underflow(underflow));

  int vectors = 0, fails = 0;
  bit supply_on = 1'b0, junk_on = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard state
  logic [DW-1:0] exp_q [$];
  int k, gap, live, bw, size_prev, seq;
  bit exp_uf, req_prev;
  logic p_de, p_hs, p_vs;
  logic [DW-1:0] p_data;

  // monitor and memory-side driver, both on the falling edge
  initial begin
    seq = 1;
    forever begin
      @(negedge clk);
      if (rst) begin
        exp_q.delete();
        k = 0; gap = 0; live = 0; bw = 0; size_prev = 0;
        exp_uf = 1'b0; req_prev = 1'b0; wr_valid = 1'b0;
      end else begin
        live++;
        gap++;
        if (live >= 2) begin
          if (pix_ce) begin
            int h, l;
            bit e_de, e_hs, e_vs;
            h = k % HT;
            l = ((k / HT) + VA) % VT;
            e_de = (h < HA) && (l < VA);
            e_hs = (h >= HA + HF) && (h < HA + HF + HS);
            e_vs = (l >= VA + VF) && (l < VA + VF + VS);
            if (k > 0) check(gap == DIV, "R2 strobe period", gap, DIV);
            gap = 0;
            check(de == e_de, "R3 R4 de", de, e_de);
            check(hsync == !e_hs, "R3 R5 hsync", hsync, !e_hs);
            check(vsync == !e_vs, "R4 R5 vsync", vsync, !e_vs);
            if (e_de && exp_q.size() > 0) begin
              logic [DW-1:0] w;
              w = exp_q.pop_front();
              check(pix_data == w, "R6 R9 pixel order", pix_data, w);
            end else if (e_de) begin
              exp_uf = 1'b1;
              check(pix_data == '0, "R10 black on empty", pix_data, 0);
            end else begin
              check(pix_data == '0, "R6 black when de low", pix_data, 0);
            end
            check(underflow == exp_uf, "R10 underflow flag", underflow, exp_uf);
            k++;
          end else begin
            check(de == p_de && hsync == p_hs && vsync == p_vs && pix_data == p_data,
                  "R2 hold between strobes", {de, hsync, vsync}, {p_de, p_hs, p_vs});
          end
          if (req_prev && !refill_req) begin
            check(bw == BURST, "R8 burst length", bw, BURST);
            bw = 0;
          end
          if (refill_req && !req_prev)
            check(size_prev <= HALF, "R7 request level", size_prev, HALF);
          if (!refill_req && !req_prev && size_prev <= HALF)
            check(1'b0, "R7 request missing", refill_req, 1);
        end
        p_de = de; p_hs = hsync; p_vs = vsync; p_data = pix_data;
        req_prev = refill_req;
        size_prev = exp_q.size();
        // memory side
        if (supply_on && refill_req && (seq % 7 != 3)) begin
          wr_valid = 1'b1;
          wr_data  = DW'(seq);
          exp_q.push_back(DW'(seq));
          bw++;
          seq++;
        end else if (supply_on && refill_req) begin
          wr_valid = 1'b0;
          seq++;
        end else if (junk_on && !refill_req) begin
          wr_valid = 1'b1;
          wr_data  = 24'hBADBAD;
        end else begin
          wr_valid = 1'b0;
        end
      end
    end
  end

  task automatic check_reset_state(input string tag);
    check(refill_req == 1'b0, {tag, " refill_req"}, refill_req, 0);
    check(de == 1'b0 && pix_ce == 1'b0, {tag, " de/pix_ce"}, {de, pix_ce}, 0);
    check(hsync == 1'b1 && vsync == 1'b1, {tag, " sync idle"}, {hsync, vsync}, 3);
    check(underflow == 1'b0, {tag, " underflow"}, underflow, 0);
    check(pix_data == '0, {tag, " pix_data"}, pix_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    supply_on = 1'b1;
    junk_on   = 1'b1;
    rst = 1'b0;
    repeat (2000) @(negedge clk);
    check(underflow == 1'b0, "R10 no underflow while fed", underflow, 0);
    // starve the buffer until it runs dry
    supply_on = 1'b0;
    junk_on   = 1'b0;
    repeat (8000) @(negedge clk);
    check(underflow == 1'b1, "R10 underflow latched", underflow, 1);
    check(refill_req == 1'b1, "R8 request held while starved", refill_req, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("R1 after rerun");
    supply_on = 1'b1;
    rst = 1'b0;
    repeat (800) @(negedge clk);
    check(underflow == 1'b0, "R10 cleared by reset", underflow, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: run did not complete, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule